// File: doc/BRIEF.md
# Pause-Width Bit Encoder Transmitter

This block turns a data word of up to `DATA_W` bits into a frame on a single carrier-enable line for a reader talking to a tag. Each bit opens with a short carrier-off gap of fixed length. The carrier then comes back on and stays on until the bit has lasted its full period. That period has one length for a 1 and another for a 0, so the receiver reads the bit value from the spacing between gaps. Bits go out least-significant first. After the last bit, one more gap closes the frame, and the carrier then returns on.

The block reports the end of the frame with a one-cycle done pulse. In the same cycle it sends a restart pulse to the shared timer that measures the tag's reply window, so that window starts counting at the end of the frame. A start request is accepted only while the block is idle. The bit count is sampled together with the data word. A count of zero sends only the closing gap. A count above `DATA_W` is clamped to `DATA_W`. All durations are parameters in clock cycles.

Top module: `pw_enc_tx`

## Requirements
- R1: After reset, carrier_o is high and busy_o, done_o and tmr_restart_o are low.
- R2: A start_i sampled high while idle loads data_i and nbits_i. From the next cycle, busy_o is high and carrier_o is low, because the first gap has begun and the bit timer starts at zero.
- R3: Every transmitted bit begins with exactly PAUSE_CYC cycles of carrier_o low.
- R4: After its gap, a bit keeps carrier_o high until the bit has lasted ONE_CYC cycles in total for a 1, or ZERO_CYC cycles for a 0.
- R5: Bits leave in order from data_i bit 0 upward.
- R6: After the last bit, carrier_o stays low for exactly PAUSE_CYC more cycles. In the cycle after that, carrier_o is high and busy_o is low.
- R7: done_o and tmr_restart_o are high together for exactly one cycle. That cycle is the first one after the closing gap, and busy_o is already low in it.
- R8: With nbits_i equal to 0, the frame consists only of the closing gap of PAUSE_CYC cycles.
- R9: An nbits_i value above DATA_W sends exactly DATA_W bits.
- R10: start_i is ignored while busy_o is high. Neither the waveform nor the frame length changes.
- R11: carrier_o is high whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send a frame; taken only when idle |
| data_i | input | DATA_W | Word to send, bit 0 first |
| nbits_i | input | $clog2(DATA_W+1) | Number of bits to send, clamped to DATA_W |
| carrier_o | output | 1 | Carrier enable: low during gaps and when the carrier is off |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse after the closing gap |
| tmr_restart_o | output | 1 | One-cycle pulse that restarts the reply-window timer |

## Verification
The bench builds the block with DATA_W = 4, PAUSE_CYC = 2, ZERO_CYC = 4 and ONE_CYC = 6. With these values it can send every 4-bit word at every count value from 0 to 7, which covers the empty frame and the clamped counts as well as every bit pattern. For each frame the bench derives the expected carrier level cycle by cycle from the timing rules and compares it with the output. In some frames it fires extra start requests partway through and checks that the frame is unaffected.

// File: rtl/pw_enc_pkg.sv
package pw_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BIT  = 2'd1,
    ST_TAIL = 2'd2
  } enc_state_e;

  // total length in cycles of one bit, gap included
  function automatic int bit_cycles(input logic b, input int zero_c, input int one_c);
    return b ? one_c : zero_c;
  endfunction

  // requested bit count limited to the word width
  function automatic int clamp_bits(input int n, input int w);
    return (n > w) ? w : n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pw_enc_timer.sv
module pw_enc_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [TW-1:0] cnt_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + TW'(1);
  end

  assign cnt_o = cnt_q;

  // a clear always brings the counter back to zero on the next cycle
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/pw_enc_shifter.sv
module pw_enc_shifter #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              shift_i,
  output logic              cur_bit_o,
  output logic              last_bit_o
);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      rem_q <= count_i;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      rem_q <= rem_q - CNT_W'(1);
    end
  end

  assign cur_bit_o  = sh_q[0];
  assign last_bit_o = (rem_q == CNT_W'(1));

  // a bit is never finished when none remain
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (rem_q != '0));

endmodule

// File: rtl/pw_enc_tx.sv
module pw_enc_tx
  import pw_enc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PAUSE_CYC = 20,
  parameter int ZERO_CYC  = 60,
  parameter int ONE_CYC   = 100,
  localparam int CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic              carrier_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tmr_restart_o
);

  localparam int LONGEST = max3(PAUSE_CYC, ZERO_CYC, ONE_CYC);
  localparam int TW      = $clog2(LONGEST + 1);

  initial begin
    p_param_order_r4: assert (PAUSE_CYC > 0 && PAUSE_CYC < ZERO_CYC &&
                              PAUSE_CYC < ONE_CYC && ZERO_CYC != ONE_CYC);
  end

  enc_state_e    state_q, state_d;
  logic [TW-1:0] cnt;
  logic          cur_bit, last_bit;
  logic          done_q, restart_q;

  // named events used by the datapath and the assertions
  logic             start_ok;
  logic             bit_end;
  logic             tail_end;
  logic             in_gap;
  logic [CNT_W-1:0] cnt_load;

  assign cnt_load = CNT_W'(clamp_bits(int'(nbits_i), DATA_W));
  assign start_ok = start_i && (state_q == ST_IDLE);
  assign bit_end  = (state_q == ST_BIT) &&
                    (cnt == TW'(bit_cycles(cur_bit, ZERO_CYC, ONE_CYC) - 1));
  assign tail_end = (state_q == ST_TAIL) && (cnt == TW'(PAUSE_CYC - 1));
  assign in_gap   = (state_q == ST_TAIL) ||
                    ((state_q == ST_BIT) && (cnt < TW'(PAUSE_CYC)));

  pw_enc_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_ok | bit_end | tail_end),
    .en_i  (state_q != ST_IDLE),
    .cnt_o (cnt)
  );

  pw_enc_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_ok),
    .data_i     (data_i),
    .count_i    (cnt_load),
    .shift_i    (bit_end),
    .cur_bit_o  (cur_bit),
    .last_bit_o (last_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = (cnt_load == '0) ? ST_TAIL : ST_BIT;
      ST_BIT:  if (bit_end)  state_d = last_bit ? ST_TAIL : ST_BIT;
      ST_TAIL: if (tail_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= tail_end;
      restart_q <= tail_end;
    end
  end

  assign carrier_o     = !in_gap;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign tmr_restart_o = restart_q;

  p_idle_carrier_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> carrier_o);

  p_start_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !carrier_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && tmr_restart_o));

  p_done_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o && !carrier_o));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tail_end) |=> busy_o);

  p_bit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BIT) |-> (cnt < TW'(LONGEST)));

endmodule

// File: tb/pw_enc_tx_test.sv
`timescale 1ns/1ps
module pw_enc_tx_test;

  localparam int DW = 4;
  localparam int PC = 2;
  localparam int ZC = 4;
  localparam int OC = 6;
  localparam int CW = $clog2(DW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [CW-1:0] nbits = '0;
  logic          carrier, busy, done, restart;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pw_enc_tx #(.DATA_W(DW), .PAUSE_CYC(PC), .ZERO_CYC(ZC), .ONE_CYC(OC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(data), .nbits_i(nbits),
    .carrier_o(carrier), .busy_o(busy), .done_o(done), .tmr_restart_o(restart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sends one frame; inject != 0 fires start requests with other data mid-frame
  task automatic run_frame(input int d, input int n, input bit inject);
    int nb, cyc, errs, first_err_act, first_err_exp;
    string tag;
    nb = (n > DW) ? DW : n;
    tag = (n == 0) ? "R8" : (n > DW) ? "R9" : inject ? "R10" : "R3/R4/R5/R6";
    @(negedge clk);
    start = 1'b1; data = DW'(d); nbits = CW'(n);
    @(negedge clk);
    start = 1'b0; data = ~DW'(d); nbits = CW'(DW);
    check(busy && !carrier, "R2", {30'd0, busy, carrier}, 2);
    errs = 0; cyc = 0; first_err_act = 0; first_err_exp = 0;
    for (int i = 0; i < nb; i++) begin
      int b, len;
      b = (d >> i) & 1;
      len = b ? OC : ZC;
      for (int k = 0; k < len; k++) begin
        bit exp_c;
        exp_c = (k >= PC);
        if (inject && (cyc == 1 || cyc == 5)) start = 1'b1;
        if (carrier !== exp_c || busy !== 1'b1) begin
          if (errs == 0) begin first_err_act = carrier; first_err_exp = exp_c; end
          errs++;
        end
        cyc++;
        @(negedge clk);
        start = 1'b0;
      end
    end
    for (int k = 0; k < PC; k++) begin
      if (inject) start = 1'b1;
      if (carrier !== 1'b0 || busy !== 1'b1) begin
        if (errs == 0) begin first_err_act = carrier; first_err_exp = 0; end
        errs++;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(errs == 0, tag, first_err_act, first_err_exp);
    check(done && restart && !busy, "R7", {29'd0, done, restart, busy}, 6);
    check(carrier === 1'b1, "R11", carrier, 1);
    @(negedge clk);
    check(!done && !restart && !busy, "R7", {29'd0, done, restart, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(carrier && !busy && !done && !restart, "R1",
          {28'd0, carrier, busy, done, restart}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(carrier && !busy, "R1", {30'd0, carrier, busy}, 2);
    for (int n = 0; n < (1 << CW); n++)
      for (int d = 0; d < (1 << DW); d++)
        run_frame(d, n, (d % 5) == 3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule